// File: doc/BRIEF.md
# AHB-Lite Word Memory Slave

This block is a 32-bit AHB-Lite slave that fronts a small on-chip memory made of byte lanes. During the address phase it registers the address, the size and the direction, but only when it is selected, the bus is ready and the transfer type is NONSEQ or SEQ. The access is then carried out in the following data phase. Write data is taken from the write bus in the last cycle of that data phase, and only the byte lanes picked out by the registered size and the low address bits are written. Read data appears in the same cycle that the slave drives its ready output high.

A parameter sets a fixed number of wait states (0 to 3) that every in-range access takes. An access outside the memory, or one with an unsupported size, gets the two-cycle ERROR response and does not touch memory. IDLE and BUSY transfers complete at once with OKAY. Incrementing and wrapping bursts need no burst decoder: each beat arrives as its own SEQ address phase, and beats are pipelined so that one beat's address phase overlaps the previous beat's data phase.

Top module: `ahb_mem_slave`

## Requirements
- R1: After the asynchronous active-low reset, ready_o reads 1, resp_o reads 0 (OKAY), rdata_o reads 0 and every memory byte reads 0.
- R2: A transfer is accepted only at a clock edge where sel_i=1, ready_i=1 and trans_i is NONSEQ (2'b10) or SEQ (2'b11). A NONSEQ write with sel_i=0 leaves memory unchanged and ready_o high.
- R3: Every in-range access holds ready_o low for exactly WAIT_STATES cycles and then drives it high for one cycle with resp_o=0. While ready_o is low for a wait state, resp_o stays 0.
- R4: An IDLE (2'b00) or BUSY (2'b01) transfer gets a zero-wait OKAY response (ready_o=1, resp_o=0 in the next cycle) and changes no memory byte.
- R5: An access whose byte address is at or above DEPTH*4, or whose size_i is above 2, gets ERROR: one cycle with ready_o=0 and resp_o=1, then one cycle with ready_o=1 and resp_o=1, with no wait states. Memory is unchanged.
- R6: A byte write (size_i=0) stores only wdata_i lane addr[1:0], that is bits 8*addr[1:0]+7 down to 8*addr[1:0].
- R7: A halfword write (size_i=1) stores lanes 0 and 1 when addr[1]=0 and lanes 2 and 3 when addr[1]=1.
- R8: A word write (size_i=2) stores all four lanes, and a later word read at the same address returns that word on rdata_o in the cycle where ready_o is high. Address bits [1:0] are ignored for word access.
- R9: Pipelined bursts work: SEQ beats issued while the previous beat's data phase is in progress complete in order. Each beat's write data is taken in its own data phase, for both incrementing and 16-byte wrapping word bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Slave select from the address decoder |
| addr_i | input | 32 | Byte address, address phase |
| trans_i | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| write_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 3 | 0 byte, 1 halfword, 2 word |
| wdata_i | input | 32 | Write data, data phase |
| ready_i | input | 1 | Bus-wide ready, previous transfer complete |
| rdata_o | output | 32 | Read data, valid when ready_o is high in a read data phase |
| ready_o | output | 1 | 1 = data phase complete, 0 = wait |
| resp_o | output | 1 | 0 = OKAY, 1 = ERROR |

## Verification
The checker watches the response shape on every cycle. It checks that an ERROR is always a low-ready cycle followed by a high-ready cycle with the error still raised, that a wait stretch never exceeds the configured count nor turns into an error, and that an IDLE or BUSY cycle is answered with a ready OKAY. The byte-lane placement, the fact that ignored or rejected transfers leave memory intact, read-back values and the ordering of pipelined incrementing and wrapping burst beats can only be shown by the bench's scenarios, which read the memory back through the bus.

// File: rtl/ahb_mem_pkg.sv
package ahb_mem_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic [2:0] {
    DP_IDLE,
    DP_WAIT,
    DP_ACCESS,
    DP_ERR1,
    DP_ERR2
  } dphase_e;

  localparam int unsigned LANES = 4;
endpackage

// File: rtl/ahb_mem_decode.sv
module ahb_mem_decode
  import ahb_mem_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [31:0]      addr_i,
  input  logic [2:0]       size_i,
  output logic             ok_o,
  output logic [LANES-1:0] strb_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [31:0] LIMIT = 32'(DEPTH * LANES);

  assign ok_o  = (size_i <= 3'd2) && (addr_i < LIMIT);
  assign idx_o = addr_i[IDX_W+1:2];

  always_comb begin
    unique case (size_i)
      3'd0:    strb_o = 4'b0001 << addr_i[1:0];
      3'd1:    strb_o = addr_i[1] ? 4'b1100 : 4'b0011;
      default: strb_o = 4'b1111;
    endcase
  end
endmodule

// File: rtl/ahb_mem_phase.sv
module ahb_mem_phase
  import ahb_mem_pkg::*;
#(
  parameter int unsigned WAIT_STATES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic ok_i,
  output logic ready_o,
  output logic resp_o,
  output logic access_o
);
  localparam int unsigned CNT_W = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'((WAIT_STATES > 0) ? WAIT_STATES - 1 : 0);

  dphase_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      DP_WAIT: begin
        if (cnt_q == '0) st_d = DP_ACCESS;
        else cnt_d = cnt_q - 1'b1;
      end
      DP_ERR1: st_d = DP_ERR2;
      default: begin
        if (!accept_i) begin
          st_d = DP_IDLE;
        end else if (!ok_i) begin
          st_d = DP_ERR1;
        end else if (WAIT_STATES == 0) begin
          st_d = DP_ACCESS;
        end else begin
          st_d  = DP_WAIT;
          cnt_d = CNT_LOAD;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= DP_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign ready_o  = !(st_q == DP_WAIT || st_q == DP_ERR1);
  assign resp_o   = (st_q == DP_ERR1) || (st_q == DP_ERR2);
  assign access_o = (st_q == DP_ACCESS);
endmodule

// File: rtl/ahb_mem_store.sv
module ahb_mem_store
  import ahb_mem_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LANES-1:0] strb_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (we_i && strb_i[l]) begin
        cells[idx_i] <= wdata_i[8*l +: 8];
      end
    end

    assign rdata_o[8*l +: 8] = cells[idx_i];
  end
endmodule

// File: rtl/ahb_mem_slave.sv
module ahb_mem_slave
  import ahb_mem_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned WAIT_STATES = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_i,
  input  logic [31:0] addr_i,
  input  logic [1:0]  trans_i,
  input  logic        write_i,
  input  logic [2:0]  size_i,
  input  logic [31:0] wdata_i,
  input  logic        ready_i,
  output logic [31:0] rdata_o,
  output logic        ready_o,
  output logic        resp_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  htrans_e          trans;
  logic             active, accept;
  logic             dec_ok;
  logic [LANES-1:0] dec_strb, strb_q;
  logic [IDX_W-1:0] dec_idx, idx_q;
  logic             write_q, access;
  logic [31:0]      mem_rdata;

  assign trans  = htrans_e'(trans_i);
  assign active = (trans == TR_NONSEQ) || (trans == TR_SEQ);
  // the slave's own ready guards against sampling while it is still stalling
  assign accept = sel_i && ready_i && ready_o && active;

  ahb_mem_decode #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_decode (
    .addr_i (addr_i),
    .size_i (size_i),
    .ok_o   (dec_ok),
    .strb_o (dec_strb),
    .idx_o  (dec_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      strb_q  <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      idx_q   <= dec_idx;
      strb_q  <= dec_strb;
      write_q <= write_i && dec_ok;
    end
  end

  ahb_mem_phase #(.WAIT_STATES(WAIT_STATES)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .ok_i     (dec_ok),
    .ready_o  (ready_o),
    .resp_o   (resp_o),
    .access_o (access)
  );

  ahb_mem_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (access && write_q),
    .strb_i  (strb_q),
    .idx_i   (idx_q),
    .wdata_i (wdata_i),
    .rdata_o (mem_rdata)
  );

  assign rdata_o = (access && !write_q) ? mem_rdata : '0;
endmodule

// File: rtl/ahb_mem_slave_chk.sv
module ahb_mem_slave_chk #(
  parameter int unsigned WAIT_STATES = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       ready_i,
  input logic [1:0] trans_i,
  input logic       ready_o,
  input logic       resp_o
);
  localparam int MAX_LOW = (WAIT_STATES > 0) ? int'(WAIT_STATES) : 1;

  logic [2:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_cnt <= '0;
    else if (ready_o) low_cnt <= '0;
    else if (low_cnt != 3'd7) low_cnt <= low_cnt + 3'd1;
  end

  assert_err_second_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_o && !ready_o) |=> (resp_o && ready_o));

  assert_err_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_o && ready_o) |-> $past(resp_o && !ready_o));

  assert_idle_okay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && ready_i && ready_o && !trans_i[1]) |=> (ready_o && !resp_o));

  assert_wait_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (int'(low_cnt) < MAX_LOW));

  assert_wait_no_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !resp_o) |=> !resp_o);
endmodule

bind ahb_mem_slave ahb_mem_slave_chk #(.WAIT_STATES(WAIT_STATES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .ready_i (ready_i),
  .trans_i (trans_i),
  .ready_o (ready_o),
  .resp_o  (resp_o)
);

// File: tb/tb_ahb_mem_slave.sv
module tb_ahb_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int WAITS      = 1;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  trans = 2'b00;
  logic        write = 1'b0;
  logic [2:0]  size = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready_out, resp;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_mem [DEPTH];
  logic [31:0] bdata [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  ahb_mem_slave #(.DEPTH(DEPTH), .WAIT_STATES(WAITS)) dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .sel_i   (sel),
    .addr_i  (addr),
    .trans_i (trans),
    .write_i (write),
    .size_i  (size),
    .wdata_i (wdata),
    .ready_i (ready_out),
    .rdata_o (rdata),
    .ready_o (ready_out),
    .resp_o  (resp)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic model_write(input logic [31:0] a, input logic [2:0] sz, input logic [31:0] wd);
    for (int b = 0; b < 4; b++) begin
      logic en;
      en = (sz == 3'd2) || (sz == 3'd1 && b[1] == a[1]) || (sz == 3'd0 && b[1:0] == a[1:0]);
      if (en) exp_mem[a[5:2]][8*b +: 8] = wd[8*b +: 8];
    end
  endtask

  // single non-pipelined transfer; returns data sampled in the completing cycle
  task automatic xfer(input logic wr, input logic [31:0] a, input logic [2:0] sz, input logic [31:0] wd,
                      output logic [31:0] rd, output int waits);
    @(negedge clk);
    sel = 1'b1; addr = a; trans = 2'b10; write = wr; size = sz;
    @(negedge clk);
    sel = 1'b0; trans = 2'b00; write = 1'b0; wdata = wd;
    waits = 0;
    while (!ready_out) begin
      waits++;
      @(negedge clk);
    end
    rd = rdata;
  endtask

  task automatic wr_word(input string req, input logic [31:0] a, input logic [2:0] sz, input logic [31:0] wd);
    logic [31:0] rd;
    int w;
    xfer(1'b1, a, sz, wd, rd, w);
    chk(req, "write wait count", 32'(w), 32'(WAITS));
    chk(req, "write resp", {31'd0, resp}, 32'd0);
    model_write(a, sz, wd);
  endtask

  task automatic rd_check(input string req, input logic [31:0] a);
    logic [31:0] rd;
    int w;
    xfer(1'b0, a, 3'd2, 32'd0, rd, w);
    chk(req, "read wait count", 32'(w), 32'(WAITS));
    chk(req, "read data", rd, exp_mem[a[5:2]]);
  endtask

  function automatic logic [31:0] beat_addr(input logic [31:0] a0, input int k, input bit wrap);
    logic [31:0] lin;
    lin = a0 + 32'(4 * k);
    return wrap ? ((a0 & ~32'hF) | (lin & 32'hF)) : lin;
  endfunction

  task automatic burst(input string req, input logic wr, input logic [31:0] a0, input bit wrap);
    @(negedge clk);
    sel = 1'b1; addr = beat_addr(a0, 0, wrap); trans = 2'b10; write = wr; size = 3'd2;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] cur;
      int w;
      cur = beat_addr(a0, k, wrap);
      @(negedge clk);
      wdata = wr ? bdata[k] : 32'd0;
      if (k < 3) begin
        addr = beat_addr(a0, k + 1, wrap); trans = 2'b11;
      end else begin
        sel = 1'b0; trans = 2'b00; write = 1'b0;
      end
      w = 0;
      while (!ready_out) begin
        w++;
        @(negedge clk);
      end
      chk(req, "burst beat wait count", 32'(w), 32'(WAITS));
      chk(req, "burst beat resp", {31'd0, resp}, 32'd0);
      if (wr) model_write(cur, 3'd2, bdata[k]);
      else chk(req, "burst read beat data", rdata, exp_mem[cur[5:2]]);
    end
  endtask

  task automatic t_reset();
    chk("R1", "ready after reset", {31'd0, ready_out}, 32'd1);
    chk("R1", "resp after reset", {31'd0, resp}, 32'd0);
    chk("R1", "rdata after reset", rdata, 32'd0);
    rd_check("R1", 32'h0000_0000);
    rd_check("R1", 32'h0000_003C);
  endtask

  task automatic t_word();
    wr_word("R8", 32'h10, 3'd2, 32'hDEAD_BEEF);
    rd_check("R8", 32'h10);
    wr_word("R8", 32'h17, 3'd2, 32'h0123_4567);
    rd_check("R8", 32'h14);
  endtask

  task automatic t_byte();
    for (int i = 0; i < 4; i++) wr_word("R6", 32'h20 + 32'(i), 3'd0, {4{8'hA0 + 8'(i)}});
    rd_check("R6", 32'h20);
    wr_word("R6", 32'h22, 3'd0, 32'h1122_3344);
    rd_check("R6", 32'h20);
  endtask

  task automatic t_half();
    wr_word("R7", 32'h24, 3'd1, 32'hAAAA_5555);
    rd_check("R7", 32'h24);
    wr_word("R7", 32'h26, 3'd1, 32'hC3C3_7E7E);
    rd_check("R7", 32'h24);
  endtask

  task automatic t_idle_busy();
    for (int t = 0; t < 2; t++) begin
      @(negedge clk);
      sel = 1'b1; addr = 32'h10; trans = 2'(t); write = 1'b1; size = 3'd2;
      @(negedge clk);
      sel = 1'b0; trans = 2'b00; write = 1'b0; wdata = 32'hFFFF_FFFF;
      chk("R4", "idle/busy ready", {31'd0, ready_out}, 32'd1);
      chk("R4", "idle/busy resp", {31'd0, resp}, 32'd0);
    end
    rd_check("R4", 32'h10);
  endtask

  task automatic t_deselected();
    @(negedge clk);
    sel = 1'b0; addr = 32'h14; trans = 2'b10; write = 1'b1; size = 3'd2;
    @(negedge clk);
    trans = 2'b00; write = 1'b0; wdata = 32'h5A5A_5A5A;
    chk("R2", "deselected ready", {31'd0, ready_out}, 32'd1);
    chk("R2", "deselected resp", {31'd0, resp}, 32'd0);
    rd_check("R2", 32'h14);
  endtask

  task automatic err_xfer(input logic [31:0] a, input logic [2:0] sz);
    @(negedge clk);
    sel = 1'b1; addr = a; trans = 2'b10; write = 1'b1; size = sz;
    @(negedge clk);
    sel = 1'b0; trans = 2'b00; write = 1'b0; wdata = 32'hBAD0_BAD0;
    chk("R5", "error cycle1 ready", {31'd0, ready_out}, 32'd0);
    chk("R5", "error cycle1 resp", {31'd0, resp}, 32'd1);
    @(negedge clk);
    chk("R5", "error cycle2 ready", {31'd0, ready_out}, 32'd1);
    chk("R5", "error cycle2 resp", {31'd0, resp}, 32'd1);
    @(negedge clk);
    chk("R5", "after error resp", {31'd0, resp}, 32'd0);
  endtask

  task automatic t_error();
    err_xfer(32'h40, 3'd2);
    rd_check("R5", 32'h00);
    err_xfer(32'h10, 3'd3);
    rd_check("R5", 32'h10);
  endtask

  task automatic t_bursts();
    bdata[0] = 32'h1111_0001; bdata[1] = 32'h2222_0002;
    bdata[2] = 32'h3333_0003; bdata[3] = 32'h4444_0004;
    burst("R9", 1'b1, 32'h00, 1'b0);
    burst("R9", 1'b0, 32'h00, 1'b0);
    bdata[0] = 32'h9000_0038; bdata[1] = 32'h9000_003C;
    bdata[2] = 32'h9000_0030; bdata[3] = 32'h9000_0034;
    burst("R9", 1'b1, 32'h38, 1'b1);
    burst("R9", 1'b0, 32'h38, 1'b1);
    rd_check("R9", 32'h30);
    rd_check("R9", 32'h3C);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word();
    t_byte();
    t_half();
    t_idle_busy();
    t_deselected();
    t_error();
    t_bursts();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule